// File: doc/BRIEF.md
# Register-Driven I2C Transaction Engine

This block is an I2C master controlled through a small byte-wide register window. The host loads a byte count, an address-phase count and any outgoing bytes into a shared buffer. It then writes a single command byte that holds the 7-bit target address and the direction bit. That one command write launches a complete bus transaction: START, address, payload, an optional repeated START, and STOP. When the bus has gone quiet again, the host reads a status byte that shows completion, a target NACK, or a bad block length.

A read can be preceded by an address phase. In that case the engine first writes the address-phase bytes from the buffer, then turns the bus around with a repeated START and reads the data back into the buffer from offset 0. In block-read mode the first byte received gives the length of the rest of the read, and the engine reports that length in the data-count register. The SCL timing comes from a half-period divider register. The bus is modelled as open-drain pull-down enables plus the sensed SDA level. While a transfer runs, the host can write only the control register, which is used for soft reset.

Top module: `i2c_txn_bridge`

## Requirements
- R1: After reset, the status register (offset 0x9) reads 0x01 and the half-period register (offset 0x4) reads 0x42. The capability register (offset 0x0) reads 0x80: bit 7 = block-read support, bits 6:5 = 01 only when the buffer is 72 bytes.
- R2: A host write to the command register (offset 0x6) starts a transaction. Status bit 0 reads 0 while the transaction runs and 1 once it has ended.
- R3: With command bit 0 = 0 the engine sends START and then the byte {address,0}. It then sends data-count (offset 0x7) bytes from buffer offset 0 upward (buffer byte i at register 0xA+i) and ends with STOP. SDA never changes while SCL is released inside a byte.
- R4: With command bit 0 = 1 and address-phase count N = bits 6:0 of offset 0x8 nonzero, the engine sends {address,0} followed by buffer bytes 0..N-1. It then issues a repeated START and {address,1}, and reads data-count bytes into the buffer from offset 0. It ACKs every byte read except the last, which it NACKs. With N = 0, only {address,1} is sent before the read.
- R5: A read always returns the full data count; bytes the target does not drive read as 0xFF.
- R6: A NACK on any address or written byte ends the transaction with STOP, and status reads 0x11 (bit 4 = NACK).
- R7: With bit 7 of offset 0x8 set, a read is a block read. The first byte read, L, is stored in buffer byte 0 and in the data-count register, and L more bytes fill buffer bytes 1..L.
- R8: In a block read, L = 0 or L > 32 makes the engine NACK the length byte and issue STOP. Status then reads 0x21 (bit 5 = length error).
- R9: One SCL half period lasts (half-period register + 1) clock cycles.
- R10: Writing the control register (offset 0x1) with bit 0 = 0 returns the engine to idle on the next cycle and releases both bus lines, so status reads 0x01.
- R11: While a transaction runs, host writes to every register except the control register are ignored. This includes the command register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The assertions assume that the command, the address-phase count and the other control registers are written only with strobes lasting one cycle. They also assume that the target never stretches SCL and never drives SDA while SCL is high inside a byte, because the SDA-stability property looks only at the master's own drive. The bench keeps to this by using a half period of at least three clocks, so the modelled target always settles its ACK and data bits well before SCL rises. Every host access in the bench is a single strobed cycle placed at the falling clock edge.

// File: rtl/i2c_txn_bridge.sv
`timescale 1ns/1ps
module i2c_txn_bridge #(
  parameter int          BUF_BYTES    = 36,
  parameter int          MAX_BLOCK    = 32,
  parameter logic [7:0]  HALF_DEFAULT = 8'h42,
  localparam int         AW           = $clog2(BUF_BYTES + 10),
  localparam int         BW           = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam logic [AW-1:0] A_CAP = 0, A_CTL = 1, A_HALF = 4, A_HOLD = 5,
                            A_CMD = 6, A_DCNT = 7, A_ACNT = 8, A_STAT = 9, A_BUF = 10;
  localparam logic [7:0] CAP = {1'b1, (BUF_BYTES == 72) ? 2'b01 : 2'b00, 5'b0};

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;
  typedef enum logic [1:0] {G_AW, G_WR, G_AR, G_RD} seg_t;

  st_t        st;
  seg_t       seg;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] tcnt, sh, idx;
  logic [7:0] ctrl_q, half_q, hold_q, cmd_q, dcnt_q, acnt_q;
  logic       nack_q, lerr_q;
  logic [7:0] buf_q [BUF_BYTES];

  wire busy = st != S_IDLE;
  wire srst = reg_we && reg_addr == A_CTL && !reg_wdata[0];
  wire host_wr = reg_we && !busy;
  wire tick = tcnt == 8'd0;
  wire is_rd = cmd_q[0];
  wire blk = acnt_q[7];
  wire [7:0] nidx = idx + 8'd1;
  wire [7:0] limit = is_rd ? {1'b0, acnt_q[6:0]} : dcnt_q;
  wire len_bad = sh == 8'd0 || sh > 8'(MAX_BLOCK);
  wire last = blk ? ((idx == 8'd0) ? len_bad : (idx == dcnt_q)) : (nidx == dcnt_q);
  wire [AW-1:0] boff = reg_addr - A_BUF;
  wire in_buf = reg_addr >= A_BUF && int'(reg_addr) < int'(A_BUF) + BUF_BYTES;
  wire direct_rd = reg_wdata[0] && acnt_q[6:0] == 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; seg <= G_AW; ph <= '0; bitn <= '0; tcnt <= '0; sh <= '0; idx <= '0;
      ctrl_q <= 8'h01; half_q <= HALF_DEFAULT; hold_q <= '0; cmd_q <= '0;
      dcnt_q <= '0; acnt_q <= '0; nack_q <= 1'b0; lerr_q <= 1'b0;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else if (srst) begin
      st <= S_IDLE; ph <= '0; tcnt <= '0; ctrl_q <= reg_wdata;
    end else begin
      if (host_wr) begin
        case (reg_addr)
          A_CTL:  ctrl_q <= reg_wdata;
          A_HALF: half_q <= reg_wdata;
          A_HOLD: hold_q <= reg_wdata;
          A_DCNT: dcnt_q <= reg_wdata;
          A_ACNT: acnt_q <= reg_wdata;
          A_CMD: begin
            cmd_q <= reg_wdata; nack_q <= 1'b0; lerr_q <= 1'b0;
            st <= S_START; ph <= '0; tcnt <= half_q;
            seg <= direct_rd ? G_AR : G_AW;
            sh <= {reg_wdata[7:1], direct_rd};
          end
          default: if (in_buf) buf_q[boff] <= reg_wdata;
        endcase
      end
      if (busy) begin
        if (!tick) tcnt <= tcnt - 8'd1;
        else begin
          tcnt <= half_q;
          case (st)
            S_START, S_STOP:
              if (ph == 2'd2) begin
                st <= (st == S_START) ? S_BIT : S_IDLE; ph <= '0; bitn <= '0;
              end else ph <= ph + 2'd1;
            S_BIT:
              if (ph == 2'd0) ph <= 2'd1;
              else begin
                ph <= '0;
                if (bitn != 4'd8) begin
                  sh <= {sh[6:0], sda_in}; bitn <= bitn + 4'd1;
                end else begin
                  bitn <= '0;
                  if (seg != G_RD && sda_in) begin
                    nack_q <= 1'b1; st <= S_STOP;
                  end else case (seg)
                    G_AW:
                      if (limit == 8'd0) st <= S_STOP;
                      else begin seg <= G_WR; idx <= '0; sh <= buf_q[0]; end
                    G_WR:
                      if (nidx == limit) begin
                        if (is_rd) begin st <= S_START; seg <= G_AR; sh <= {cmd_q[7:1], 1'b1}; end
                        else st <= S_STOP;
                      end else begin idx <= nidx; sh <= buf_q[nidx[BW-1:0]]; end
                    G_AR:
                      if (!blk && dcnt_q == 8'd0) st <= S_STOP;
                      else begin seg <= G_RD; idx <= '0; end
                    default: begin
                      if (int'(idx) < BUF_BYTES) buf_q[idx[BW-1:0]] <= sh;
                      if (blk && idx == 8'd0) dcnt_q <= sh;
                      if (last) begin
                        st <= S_STOP;
                        if (blk && idx == 8'd0) lerr_q <= 1'b1;
                      end else idx <= nidx;
                    end
                  endcase
                end
              end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = ph == 2'd0; sda_oe = ph == 2'd2; end
      S_STOP:  begin scl_oe = ph == 2'd0; sda_oe = ph != 2'd2; end
      S_BIT: begin
        scl_oe = ph == 2'd0;
        sda_oe = (bitn == 4'd8) ? (seg == G_RD && !last) : (seg != G_RD && !sh[7]);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CAP:  reg_rdata = CAP;
      A_CTL:  reg_rdata = ctrl_q;
      A_HALF: reg_rdata = half_q;
      A_HOLD: reg_rdata = hold_q;
      A_CMD:  reg_rdata = cmd_q;
      A_DCNT: reg_rdata = dcnt_q;
      A_ACNT: reg_rdata = acnt_q;
      A_STAT: reg_rdata = {2'b00, lerr_q, nack_q, 3'b000, !busy};
      default: reg_rdata = in_buf ? buf_q[boff] : 8'h00;
    endcase
  end

  p_cmd_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && !busy) |=> (st == S_START));
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (st == S_IDLE && !scl_oe && !sda_oe));
  p_acnt_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_ACNT) |=> $stable(acnt_q));
  p_cmd_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_CMD) |=> $stable(cmd_q));
endmodule

// File: tb/test_i2c_txn_bridge.sv
`timescale 1ns/1ps
module test_i2c_txn_bridge;
  localparam logic [6:0] TGT = 7'h50;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe, s_oe = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | s_oe);
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tx_mem [8];
  int tx_len = 0, nack_at = -1;

  always #2.5 clk = ~clk;

  i2c_txn_bridge i_i2c_txn_bridge (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin errors++; $display("FAIL %s: got %h expected %h", req, got, exp); end
  endtask

  task automatic expect_byte(input logic [7:0] b); exp_q.push_back(b); endtask

  task automatic sb_check(input logic [7:0] b);
    checks++;
    if (exp_q.size() == 0) begin errors++; $display("FAIL R3 bus byte: got %h expected none", b); end
    else begin
      logic [7:0] e = exp_q.pop_front();
      if (b !== e) begin errors++; $display("FAIL R3 bus byte: got %h expected %h", b, e); end
    end
  endtask

  function automatic logic drv(input int p, input int b);
    return p < tx_len && p < 8 && !tx_mem[p][b];
  endfunction

  // target model: ACKs TGT, checks every byte it receives against the scoreboard
  logic ps = 1'b1, pd = 1'b1, act = 1'b0, first = 1'b0, dtx = 1'b0, rw = 1'b0, mack = 1'b0;
  logic [3:0] cnt = '0;
  logic [7:0] rx = '0;
  int rptr = 0, wcnt = 0;
  always @(posedge clk) begin
    ps <= scl; pd <= sda;
    if (ps && scl && pd && !sda) begin
      act <= 1'b1; first <= 1'b1; dtx <= 1'b0; cnt <= '0; s_oe <= 1'b0; rptr <= 0; wcnt <= 0;
    end else if (ps && scl && !pd && sda) begin
      act <= 1'b0; s_oe <= 1'b0;
    end else if (act && !ps && scl) begin
      if (cnt < 8) rx <= {rx[6:0], sda}; else if (dtx) mack <= sda;
      cnt <= cnt + 4'd1;
    end else if (act && ps && !scl) begin
      if (cnt == 8) begin
        if (dtx) s_oe <= 1'b0;
        else begin
          sb_check(rx);
          if (first) begin
            rw <= rx[0]; s_oe <= rx[7:1] == TGT;
            if (rx[7:1] != TGT) act <= 1'b0;
          end else begin s_oe <= wcnt != nack_at; wcnt <= wcnt + 1; end
        end
      end else if (cnt == 9) begin
        cnt <= '0;
        if (first) begin first <= 1'b0; dtx <= rw; s_oe <= rw && drv(0, 7); end
        else if (dtx && !mack) begin rptr <= rptr + 1; s_oe <= drv(rptr + 1, 7); end
        else begin s_oe <= 1'b0; if (dtx) act <= 1'b0; end
      end else if (dtx) s_oe <= drv(rptr, 7 - int'(cnt));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h09, s);
      if (s[0]) return;
    end
    errors++; $display("FAIL %s: got busy expected idle", req);
  endtask

  task automatic sb_empty(input string req);
    chk(req, 8'(exp_q.size()), 8'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    time t1, t2;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    rd(6'h09, v); chk("R1 status", v, 8'h01);
    rd(6'h04, v); chk("R1 half", v, 8'h42);
    rd(6'h00, v); chk("R1 cap", v, 8'h80);

    // R9 SCL period with half = 4
    wr(6'h04, 8'h04); wr(6'h07, 8'd1); wr(6'h0A, 8'h5C);
    expect_byte(8'hA0); expect_byte(8'h5C);
    wr(6'h06, 8'hA0);
    @(posedge scl_oe); @(posedge scl_oe); t1 = $time; @(posedge scl_oe); t2 = $time;
    chk("R9 scl period", 8'((t2 - t1) / 5), 8'd10);
    wait_idle("R9"); sb_empty("R9 bytes");

    // R3 / R2 write of three bytes
    wr(6'h04, 8'h02); wr(6'h07, 8'd3);
    wr(6'h0A, 8'h11); wr(6'h0B, 8'h22); wr(6'h0C, 8'h33);
    expect_byte(8'hA0); expect_byte(8'h11); expect_byte(8'h22); expect_byte(8'h33);
    wr(6'h06, 8'hA0);
    rd(6'h09, v); chk("R2 busy", v, 8'h00);
    wait_idle("R3"); rd(6'h09, v); chk("R2 done", v, 8'h01); sb_empty("R3 bytes");

    // R4 combined read
    wr(6'h08, 8'h02); wr(6'h0A, 8'h12); wr(6'h0B, 8'h34);
    tx_mem[0] = 8'h5A; tx_mem[1] = 8'h6B; tx_mem[2] = 8'h7C; tx_len = 3;
    expect_byte(8'hA0); expect_byte(8'h12); expect_byte(8'h34); expect_byte(8'hA1);
    wr(6'h06, 8'hA1); wait_idle("R4");
    rd(6'h0A, v); chk("R4 rd0", v, 8'h5A);
    rd(6'h0B, v); chk("R4 rd1", v, 8'h6B);
    rd(6'h0C, v); chk("R4 rd2", v, 8'h7C);
    rd(6'h09, v); chk("R4 status", v, 8'h01); sb_empty("R4 bytes");

    // R5 pull-up bytes, direct read
    wr(6'h08, 8'h00); tx_mem[0] = 8'hD0; tx_len = 1;
    expect_byte(8'hA1);
    wr(6'h06, 8'hA1); wait_idle("R5");
    rd(6'h0A, v); chk("R5 rd0", v, 8'hD0);
    rd(6'h0B, v); chk("R5 rd1", v, 8'hFF);
    rd(6'h0C, v); chk("R5 rd2", v, 8'hFF); sb_empty("R5 bytes");

    // R6 address NACK
    wr(6'h07, 8'd1); expect_byte(8'h66);
    wr(6'h06, 8'h66); wait_idle("R6a");
    rd(6'h09, v); chk("R6 addr nack", v, 8'h11); sb_empty("R6 addr bytes");

    // R6 data NACK on second data byte
    wr(6'h07, 8'd3); wr(6'h0A, 8'hAA); wr(6'h0B, 8'hBB); wr(6'h0C, 8'hCC);
    nack_at = 1; expect_byte(8'hA0); expect_byte(8'hAA); expect_byte(8'hBB);
    wr(6'h06, 8'hA0); wait_idle("R6d");
    rd(6'h09, v); chk("R6 data nack", v, 8'h11); sb_empty("R6 data bytes"); nack_at = -1;

    // R7 block read
    wr(6'h08, 8'h81); wr(6'h0A, 8'h20); wr(6'h07, 8'd9);
    tx_mem[0] = 8'd3; tx_mem[1] = 8'hC1; tx_mem[2] = 8'hC2; tx_mem[3] = 8'hC3; tx_len = 4;
    expect_byte(8'hA0); expect_byte(8'h20); expect_byte(8'hA1);
    wr(6'h06, 8'hA1); wait_idle("R7");
    rd(6'h07, v); chk("R7 count", v, 8'd3);
    rd(6'h0A, v); chk("R7 len byte", v, 8'd3);
    rd(6'h0B, v); chk("R7 b1", v, 8'hC1);
    rd(6'h0D, v); chk("R7 b3", v, 8'hC3);
    rd(6'h09, v); chk("R7 status", v, 8'h01); sb_empty("R7 bytes");

    // R8 block length error
    wr(6'h0A, 8'h20); tx_mem[0] = 8'd40;
    expect_byte(8'hA0); expect_byte(8'h20); expect_byte(8'hA1);
    wr(6'h06, 8'hA1); wait_idle("R8");
    rd(6'h09, v); chk("R8 status", v, 8'h21);
    rd(6'h07, v); chk("R8 count", v, 8'd40); sb_empty("R8 bytes");

    // R11 writes ignored while busy
    wr(6'h08, 8'h00); wr(6'h07, 8'd1); wr(6'h0A, 8'h77);
    expect_byte(8'hA0); expect_byte(8'h77);
    wr(6'h06, 8'hA0); wr(6'h08, 8'h03); wr(6'h06, 8'h66); wr(6'h07, 8'd5);
    wait_idle("R11"); repeat (200) @(negedge clk);
    rd(6'h08, v); chk("R11 acnt kept", v, 8'h00);
    rd(6'h06, v); chk("R11 cmd kept", v, 8'hA0);
    rd(6'h07, v); chk("R11 dcnt kept", v, 8'd1);
    rd(6'h09, v); chk("R11 no new txn", v, 8'h01); sb_empty("R11 bytes");

    // R10 soft reset during START
    wr(6'h06, 8'hA0); repeat (2) @(negedge clk);
    wr(6'h01, 8'h00);
    rd(6'h09, v); chk("R10 status", v, 8'h01);
    chk("R10 bus released", {6'b0, scl_oe, sda_oe}, 8'h00);
    wr(6'h01, 8'h01);
    expect_byte(8'hA0); expect_byte(8'h77);
    wr(6'h06, 8'hA0); wait_idle("R10 after");
    rd(6'h09, v); chk("R10 next txn", v, 8'h01); sb_empty("R10 bytes");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule